// File: doc/BRIEF.md
# Compare-Match PWM Timer

This block is a bank of independent 16-bit up-counters. Software drives it through a small memory-mapped bus with 16-bit writes and reads. Each channel counts a prescaled version of the system clock. Four compare registers are set against the count. One of them may be chosen to reset the counter, which gives a programmable period. A match on compare register A drives the channel's output pin.

In PWM mode, compare register B (chosen as the reset source) sets the period and register A sets the duty point. The pin starts each period at a programmed idle level. It moves to the action level when register A matches and goes back to the idle level when the period ends. A shared start register holds one run bit per channel, so channels can be started and stopped together.

For a fixed 0% or 100% output, software halts the channel and rewrites the pin control register. The pin then takes the programmed idle level at once.

Top module: `cmt_pwm_unit`

Register map (byte addresses):
- The start register is at 0x00. Bit n runs channel n, and bits at or above the channel count read as zero.
- Channel n occupies the window 0x10 + 0x40·n.
- Offsets inside a channel window are: counter control 0x00, mode 0x04, pin control 0x08, counter 0x14, and compare registers A, B, C and D at 0x18, 0x1C, 0x20 and 0x24.
- Offsets 0x0C and 0x10 read as zero and ignore writes.

## Requirements
- R1: After reset, every register reads zero, every channel is halted and every pin is low.
- R2: The counter control register stores bits [7:3] and [1:0], and bit 2 reads zero. The mode register stores bits [1:0]. The pin control register stores bits [2:0]. The counter and compare registers A to D store all 16 bits. Offsets 0x0C and 0x10 read zero whatever is written. The start register keeps only one bit per channel.
- R3: While its run bit is 0, a channel's counter holds its value. While running, the counter adds one on each count event.
- R4: Control bits [1:0] set the divide ratio: 0 is /1, 1 is /4, 2 is /16, 3 is /64. Control bits [4:3] pick the counting edge of the divided clock: 0 rising, 1 falling, 2 or 3 both. The divider restarts whenever the channel halts. As a result, a run of exactly M cycles gives this many counts: M at /1; M/4 for one edge at /4 with M a multiple of 4; twice that for both edges; floor((M+8)/16) rising at /16; floor((M+32)/64) rising at /64.
- R5: Control bits [7:5] pick what resets the counter: 1 is a match on A, 2 on B, 5 on C, 6 on D, and any other value means never. A count event that finds the counter equal to the chosen register loads zero instead of adding one. With no reset source, the counter wraps from 0xFFFF to 0.
- R6: In the pin control register, bit 2 is the idle level and bits [1:0] are the match action: 0 none, 1 drive low, 2 drive high, 3 invert. A write to this register while the channel is halted drives the pin to the new bit 2 on the next clock.
- R7: In normal mode (mode bits other than 2), a count event that finds the counter equal to A applies the match action to the pin.
- R8: In PWM mode (mode bits = 2), the pin also goes back to the idle level on a count event at which the reset-source match occurs. With B as the reset source, from a count of zero the pin keeps the idle level for A+1 count events, then the action level for B−A count events.
- R9: When A and the reset source match on the same count event, the A action wins. So A equal to B keeps the action level steady, and A greater than B keeps the idle level steady.
- R10: Each run bit starts and stops only its own channel.
- R11: A bus write to the counter takes effect on the next clock even while the channel runs, and it overrides that cycle's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one word per cycle |
| bus_addr_i | input | ADDR_W (8) | Byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| pwm_o | output | N_CH (3) | One output pin per channel |

## Verification
A counter stuck, skipping or clearing at the wrong value shows in the counter readback as soon as the channel halts. The PWM pin shows a wrong idle or action phase within one period, because the pin is compared on every cycle against a waveform derived from A and B. A divider that is not cleared on halt, or a wrong edge choice, changes the count after a run of a known number of cycles by at least one. A pin control write taken while the channel runs, or one ignored while it is halted, shows on the pin one cycle after the write.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned N_CMP  = 4;
  localparam int unsigned DIV_W  = 6;   // enough for /64

  localparam logic [5:0] OFF_CTRL = 6'h00;
  localparam logic [5:0] OFF_MODE = 6'h04;
  localparam logic [5:0] OFF_PCTL = 6'h08;
  localparam logic [5:0] OFF_CNT  = 6'h14;
  localparam logic [5:0] OFF_CMP0 = 6'h18;

  localparam logic [2:0] RST_ON_A = 3'd1;
  localparam logic [2:0] RST_ON_B = 3'd2;
  localparam logic [2:0] RST_ON_C = 3'd5;
  localparam logic [2:0] RST_ON_D = 3'd6;

  localparam logic [1:0] MODE_PWM = 2'd2;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_INV  = 2'd3
  } pin_act_e;

  typedef enum logic [1:0] {
    EDG_RISE  = 2'd0,
    EDG_FALL  = 2'd1,
    EDG_BOTH  = 2'd2,
    EDG_BOTHX = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic [2:0] rst_src;
    edge_sel_e  edge_sel;
    logic [1:0] div_sel;
  } ctrl_t;

  typedef struct packed {
    logic     idle_lvl;
    pin_act_e act;
  } pctl_t;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic [1:0] div_sel_i,
  input  edge_sel_e edge_sel_i,
  output logic      tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] low_mask;
  logic [2:0]       bidx;
  logic             low_all, hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  // divided clock is div_q[bidx]; its edges occur when all lower bits are ones
  always_comb begin
    bidx     = {div_sel_i, 1'b0} - 3'd1;
    low_mask = (DIV_W'(1) << bidx) - DIV_W'(1);
    low_all  = &(div_q | ~low_mask);
    hi       = |(div_q & (DIV_W'(1) << bidx));
    if (div_sel_i == 2'd0) tick_o = 1'b1;
    else begin
      unique case (edge_sel_i)
        EDG_RISE: tick_o = low_all & ~hi;
        EDG_FALL: tick_o = low_all & hi;
        default:  tick_o = low_all;
      endcase
    end
  end

  assert_no_back_to_back_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_o && div_sel_i != 2'd0) |=>
      (!tick_o || !run_i || !$stable(div_sel_i) || !$stable(edge_sel_i)));

  assert_halt_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && div_sel_i != 2'd0) |=> (!tick_o || edge_sel_i != EDG_RISE || div_sel_i == 2'd0 || run_i));
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             we_i,
  input  logic [5:0]       off_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             pin_o
);
  ctrl_t            ctrl_q;
  logic [1:0]       mode_q;
  pctl_t            pctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q [N_CMP];
  logic             pin_q;

  logic tick, step, rst_hit, hit_a, cnt_we, pctl_we, is_pwm;

  cmt_prescaler u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .div_sel_i (ctrl_q.div_sel),
    .edge_sel_i(ctrl_q.edge_sel),
    .tick_o    (tick)
  );

  assign cnt_we  = we_i && off_i == OFF_CNT;
  assign pctl_we = we_i && off_i == OFF_PCTL;
  assign step    = run_i && tick;
  assign is_pwm  = mode_q == MODE_PWM;
  assign hit_a   = cnt_q == cmp_q[0];

  always_comb begin
    unique case (ctrl_q.rst_src)
      RST_ON_A: rst_hit = cnt_q == cmp_q[0];
      RST_ON_B: rst_hit = cnt_q == cmp_q[1];
      RST_ON_C: rst_hit = cnt_q == cmp_q[2];
      RST_ON_D: rst_hit = cnt_q == cmp_q[3];
      default:  rst_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      pctl_q <= '0;
    end else if (we_i) begin
      if (off_i == OFF_CTRL) ctrl_q <= ctrl_t'({wdata_i[7:3], wdata_i[1:0]});
      if (off_i == OFF_MODE) mode_q <= wdata_i[1:0];
      if (off_i == OFF_PCTL) pctl_q <= pctl_t'(wdata_i[2:0]);
    end
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    localparam logic [5:0] OFF_I = 6'(OFF_CMP0 + 4 * i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     cmp_q[i] <= '0;
      else if (we_i && off_i == OFF_I) cmp_q[i] <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_we) cnt_q <= wdata_i[CNT_W-1:0];
    else if (step)   cnt_q <= rst_hit ? '0 : cnt_q + 1'b1;
  end

  // A action has priority over the end-of-period return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else if (pctl_we && !run_i) pin_q <= wdata_i[2];
    else if (step) begin
      if (hit_a) begin
        unique case (pctl_q.act)
          ACT_LOW:  pin_q <= 1'b0;
          ACT_HIGH: pin_q <= 1'b1;
          ACT_INV:  pin_q <= ~pin_q;
          default:  pin_q <= pin_q;
        endcase
      end else if (is_pwm && rst_hit) begin
        pin_q <= pctl_q.idle_lvl;
      end
    end
  end

  assign pin_o = pin_q;

  always_comb begin
    rdata_o = '0;
    unique case (off_i)
      OFF_CTRL: rdata_o = REG_W'({ctrl_q.rst_src, ctrl_q.edge_sel, 1'b0, ctrl_q.div_sel});
      OFF_MODE: rdata_o = REG_W'(mode_q);
      OFF_PCTL: rdata_o = REG_W'(pctl_q);
      OFF_CNT:  rdata_o = REG_W'(cnt_q);
      6'h18:    rdata_o = REG_W'(cmp_q[0]);
      6'h1C:    rdata_o = REG_W'(cmp_q[1]);
      6'h20:    rdata_o = REG_W'(cmp_q[2]);
      6'h24:    rdata_o = REG_W'(cmp_q[3]);
      default:  rdata_o = '0;
    endcase
  end

  assert_hold_halted_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we) |=> $stable(cnt_q));

  assert_step_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !rst_hit && !cnt_we) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_reset_to_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && rst_hit && !cnt_we) |=> cnt_q == '0);

  assert_idle_on_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pctl_we && !run_i) |=> pin_o == $past(wdata_i[2]));

  assert_pin_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !pctl_we) |=> $stable(pin_o));

  assert_period_return_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && is_pwm && rst_hit && !hit_a && !pctl_we) |=> pin_o == pctl_q.idle_lvl);

  assert_no_step_no_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !step) |=> $stable(pin_o));
endmodule

// File: rtl/cmt_pwm_unit.sv
module cmt_pwm_unit
  import cmt_pkg::*;
#(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic [N_CH-1:0]   pwm_o
);
  localparam int unsigned CH_BASE = 16;
  localparam int unsigned SPAN_LG = 6;

  logic [N_CH-1:0]   run_q;
  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] ch_idx;
  logic              in_ch, start_sel;
  logic [REG_W-1:0]  ch_rdata [N_CH];

  assign start_sel = bus_addr_i == '0;
  assign in_ch     = bus_addr_i >= ADDR_W'(CH_BASE);
  assign rel       = bus_addr_i - ADDR_W'(CH_BASE);
  assign ch_idx    = rel >> SPAN_LG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    run_q <= '0;
    else if (bus_we_i && start_sel) run_q <= bus_wdata_i[N_CH-1:0];
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic sel;
    assign sel = in_ch && ch_idx == ADDR_W'(g);
    cmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_q[g]),
      .we_i   (bus_we_i && sel),
      .off_i  (rel[SPAN_LG-1:0]),
      .wdata_i(bus_wdata_i),
      .rdata_o(ch_rdata[g]),
      .pin_o  (pwm_o[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (start_sel) bus_rdata_o = REG_W'(run_q);
    else if (in_ch) begin
      for (int i = 0; i < N_CH; i++)
        if (ch_idx == ADDR_W'(i)) bus_rdata_o = ch_rdata[i];
    end
  end

  assert_run_bits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && start_sel) |=> run_q == $past(bus_wdata_i[N_CH-1:0]));

  assert_run_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && start_sel) |=> $stable(run_q));
endmodule

// File: tb/tb_cmt_pwm_unit.sv
module tb_cmt_pwm_unit;
  localparam logic [5:0] O_CTRL = 6'h00, O_MODE = 6'h04, O_PCTL = 6'h08, O_IEN = 6'h0C,
                         O_STAT = 6'h10, O_CNT = 6'h14, O_A = 6'h18, O_B = 6'h1C,
                         O_C = 6'h20, O_D = 6'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  pwm;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_pin;
    int          idx;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  cmt_pwm_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm)
  );

  function automatic logic [7:0] ca(int ch, logic [5:0] off);
    return 8'(16 + ch * 64 + int'(off));
  endfunction

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk_rd(logic [7:0] a, logic [15:0] e, string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.is_pin = 1'b0; it.idx = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    #2;
  endtask

  task automatic chk_pin(int ch, logic e, string tag);
    item_t it;
    @(negedge clk);
    it.is_pin = 1'b1; it.idx = ch; it.exp = 16'(e); it.tag = tag;
    sb.push_back(it);
    #2;
  endtask

  // run channels in mask for exactly m count edges (m >= 2)
  task automatic run_for(logic [15:0] mask, int m);
    wr(8'h00, mask);
    repeat (m - 2) @(negedge clk);
    wr(8'h00, 16'h0000);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb.pop_front();
        act = it.is_pin ? 16'(pwm[it.idx]) : rdata;
        checks++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_rd(8'h00, 16'h0000, "R1 start reg");
    chk_rd(ca(0, O_CNT), 16'h0000, "R1 ch0 counter");
    chk_rd(ca(2, O_B), 16'h0000, "R1 ch2 cmpB");
    chk_rd(ca(1, O_CTRL), 16'h0000, "R1 ch1 ctrl");
    chk_pin(0, 1'b0, "R1 pin0");
    chk_pin(2, 1'b0, "R1 pin2");

    // R2 register storage
    wr(ca(0, O_CTRL), 16'hFFFF);  chk_rd(ca(0, O_CTRL), 16'h00FB, "R2 ctrl mask");
    wr(ca(0, O_MODE), 16'h0072);  chk_rd(ca(0, O_MODE), 16'h0002, "R2 mode mask");
    wr(ca(0, O_IEN), 16'hFFFF);   chk_rd(ca(0, O_IEN), 16'h0000, "R2 ien reads zero");
    wr(ca(0, O_STAT), 16'hFFFF);  chk_rd(ca(0, O_STAT), 16'h0000, "R2 status reads zero");
    wr(ca(1, O_C), 16'hBEEF);     chk_rd(ca(1, O_C), 16'hBEEF, "R2 cmpC");
    wr(ca(1, O_D), 16'h1234);     chk_rd(ca(1, O_D), 16'h1234, "R2 cmpD");
    wr(ca(0, O_PCTL), 16'h00FF);  chk_rd(ca(0, O_PCTL), 16'h0007, "R2 pin ctrl mask");
    chk_pin(0, 1'b1, "R6 halted write drives idle high");
    wr(ca(0, O_PCTL), 16'h0000);
    chk_pin(0, 1'b0, "R6 halted write drives idle low");
    wr(ca(0, O_CTRL), 16'h0000);
    wr(ca(0, O_MODE), 16'h0000);
    wr(8'h00, 16'hFFF8);          chk_rd(8'h00, 16'h0000, "R2 start keeps channel bits only");

    // R3/R4 counting and prescaler
    wr(ca(0, O_CNT), 0); run_for(1, 7);
    chk_rd(ca(0, O_CNT), 16'd7, "R3 count per cycle at /1");
    repeat (5) @(negedge clk);
    chk_rd(ca(0, O_CNT), 16'd7, "R3 counter holds while halted");
    wr(ca(0, O_CTRL), 16'h0001); wr(ca(0, O_CNT), 0); run_for(1, 12);
    chk_rd(ca(0, O_CNT), 16'd3, "R4 /4 rising");
    wr(ca(0, O_CTRL), 16'h0009); wr(ca(0, O_CNT), 0); run_for(1, 12);
    chk_rd(ca(0, O_CNT), 16'd3, "R4 /4 falling");
    wr(ca(0, O_CTRL), 16'h0011); wr(ca(0, O_CNT), 0); run_for(1, 12);
    chk_rd(ca(0, O_CNT), 16'd6, "R4 /4 both edges");
    wr(ca(0, O_CTRL), 16'h0002); wr(ca(0, O_CNT), 0); run_for(1, 40);
    chk_rd(ca(0, O_CNT), 16'd3, "R4 /16 rising");
    wr(ca(0, O_CTRL), 16'h0003); wr(ca(0, O_CNT), 0); run_for(1, 70);
    chk_rd(ca(0, O_CNT), 16'd1, "R4 /64 rising");

    // R5 reset source selection, counter value = M mod (X+1)
    wr(ca(0, O_A), 16'd4); wr(ca(0, O_B), 16'd6); wr(ca(0, O_C), 16'd3); wr(ca(0, O_D), 16'd7);
    wr(ca(0, O_CTRL), 16'h0020); wr(ca(0, O_CNT), 0); run_for(1, 13);
    chk_rd(ca(0, O_CNT), 16'd3, "R5 reset on A");
    wr(ca(0, O_CTRL), 16'h0040); wr(ca(0, O_CNT), 0); run_for(1, 13);
    chk_rd(ca(0, O_CNT), 16'd6, "R5 reset on B");
    wr(ca(0, O_CTRL), 16'h00A0); wr(ca(0, O_CNT), 0); run_for(1, 13);
    chk_rd(ca(0, O_CNT), 16'd1, "R5 reset on C");
    wr(ca(0, O_CTRL), 16'h00C0); wr(ca(0, O_CNT), 0); run_for(1, 13);
    chk_rd(ca(0, O_CNT), 16'd5, "R5 reset on D");
    wr(ca(0, O_CTRL), 16'h0000); wr(ca(0, O_CNT), 16'hFFFC); run_for(1, 6);
    chk_rd(ca(0, O_CNT), 16'h0002, "R5 wrap without reset source");

    // R7 normal mode actions on channel 2, A=2, 10 counts from 0
    wr(ca(2, O_A), 16'd2);
    wr(ca(2, O_PCTL), 16'h0003); chk_pin(2, 1'b0, "R6 idle low");
    wr(ca(2, O_CNT), 0); run_for(4, 10);
    chk_pin(2, 1'b1, "R7 invert once");
    chk_rd(ca(2, O_CNT), 16'd10, "R7 counter after run");
    wr(ca(2, O_CNT), 0); run_for(4, 10);
    chk_pin(2, 1'b0, "R7 invert again");
    wr(ca(2, O_PCTL), 16'h0005); chk_pin(2, 1'b1, "R6 idle high");
    wr(ca(2, O_CNT), 0); run_for(4, 10);
    chk_pin(2, 1'b0, "R7 drive low");
    wr(ca(2, O_PCTL), 16'h0002);
    wr(ca(2, O_CNT), 0); run_for(4, 10);
    chk_pin(2, 1'b1, "R7 drive high");
    wr(ca(2, O_PCTL), 16'h0004);
    wr(ca(2, O_CNT), 0); run_for(4, 10);
    chk_pin(2, 1'b1, "R7 no action keeps level");

    // R8 PWM on channel 0: A=3, B=9, reset on B
    wr(ca(0, O_CTRL), 16'h0040); wr(ca(0, O_MODE), 16'h0002);
    wr(ca(0, O_A), 16'd3); wr(ca(0, O_B), 16'd9);
    wr(ca(0, O_PCTL), 16'h0002); wr(ca(0, O_CNT), 0);
    wr(8'h00, 16'h0001);
    for (int e = 1; e <= 25; e++) chk_pin(0, (e % 10) >= 4, "R8 pwm idle low");
    wr(8'h00, 16'h0000);
    wr(ca(0, O_PCTL), 16'h0005); wr(ca(0, O_CNT), 0);
    wr(8'h00, 16'h0001);
    for (int e = 1; e <= 25; e++) chk_pin(0, !((e % 10) >= 4), "R8 pwm idle high");
    wr(8'h00, 16'h0000);

    // R9 coincident matches
    wr(ca(0, O_A), 16'd5); wr(ca(0, O_B), 16'd5);
    wr(ca(0, O_PCTL), 16'h0002); wr(ca(0, O_CNT), 0);
    wr(8'h00, 16'h0001);
    for (int e = 1; e <= 20; e++) chk_pin(0, e >= 6, "R9 A equal B full level");
    wr(8'h00, 16'h0000);
    wr(ca(0, O_A), 16'd8); wr(ca(0, O_B), 16'd5);
    wr(ca(0, O_PCTL), 16'h0005); wr(ca(0, O_CNT), 0);
    wr(8'h00, 16'h0001);
    for (int e = 1; e <= 15; e++) chk_pin(0, 1'b1, "R9 A above B keeps idle");
    wr(8'h00, 16'h0000);

    // R10 independent run bits
    wr(ca(0, O_CNT), 0); wr(ca(1, O_CTRL), 0); wr(ca(1, O_CNT), 0);
    run_for(2, 8);
    chk_rd(ca(1, O_CNT), 16'd8, "R10 running channel counts");
    chk_rd(ca(0, O_CNT), 16'd0, "R10 other channel untouched");
    wr(8'h00, 16'h0006); chk_rd(8'h00, 16'h0006, "R10 start readback");
    wr(8'h00, 16'h0000);

    // R11 counter write while running
    wr(ca(1, O_CNT), 0);
    wr(8'h00, 16'h0002);
    repeat (3) @(negedge clk);
    wr(ca(1, O_CNT), 16'd100);
    wr(8'h00, 16'h0000);
    chk_rd(ca(1, O_CNT), 16'd102, "R11 write overrides running count");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule